// File: doc/BRIEF.md
# Nibble-Addressed DAC Input Register Interface

This block is the digital front end of a 12-bit parallel-input digital-to-analog converter. A host writes the converter word over a narrow data bus in nibble-sized pieces. A 2-bit select field, qualified by active-low chip-select and write strobes, picks which of three 4-bit holding registers takes the data. The low, middle and high nibbles together form the assembled input word. Select value 00 fills the low and middle nibbles at once, so the word can be loaded either as three 4-bit transfers or as one 8-bit transfer followed by one 4-bit transfer.

The converter code is double-buffered. An active-low load strobe copies the assembled input word into a separate output register that drives the 12-bit code output. The load strobe does not depend on chip select, so several converters sharing a bus can be updated together. An active-low clear zeroes the output register and leaves the holding registers alone. A flag reports when the output code is zero, and the host may treat that state as a low-power idle condition.

All four control pins are asynchronous. They pass through a parameterised synchroniser chain before any logic uses them. A write commits on the deasserting edge of the combined strobe, with the bus and select values that were present while the strobe was active.

Top module: `nib_dac_if`

## Requirements
- R1: On synchronous active-high reset, `dac_code` is 0, `dac_zero` is 1, and all three holding nibbles are 0. A load after reset with no writes yields code 0.
- R2: Select `sel` = 00 (`sel[1]`=0, `sel[0]`=0) writes `data[7:0]` into code bits 7:0 (low and middle nibbles) in one transfer. The high nibble is unchanged.
- R3: `sel` = 10 writes `data[3:0]` into code bits 3:0 only.
- R4: `sel` = 01 writes `data[7:4]` into code bits 7:4 only.
- R5: `sel` = 11 writes `data[3:0]` into code bits 11:8 only. `data[7:4]` is ignored.
- R6: No holding register changes unless `cs_n` and `wr_n` are both low. Either strobe low on its own has no effect.
- R7: A write commits when the synchronised combined strobe deasserts. It changes only the holding registers. `dac_code` keeps its value until a load.
- R8: While the synchronised `ld_n` is low (and clear is inactive), `dac_code` follows the holding registers every cycle, whatever the state of `cs_n`.
- R9: While the synchronised `clr_n` is low, `dac_code` is 0. Clear takes priority over load.
- R10: Clear leaves the holding registers untouched, so a later load restores the last written word.
- R11: `dac_zero` is 1 exactly when `dac_code` is 0.
- R12: A change on `ld_n` or `clr_n` first affects `dac_code` after SYNC_STAGES+1 rising edges, counting the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe into the output register, active low, asynchronous |
| clr_n | input | 1 | Clear of the output register, active low, asynchronous |
| sel | input | 2 | Holding-register select (bit 1, bit 0) |
| data | input | 2*NIB_W | Data bus |
| dac_code | output | 3*NIB_W | Registered converter code |
| dac_zero | output | 1 | High when dac_code is zero |

## Verification
The bench builds the block with NIB_W=4 and SYNC_STAGES=3. The deeper chain separates a strobe's raw edge from its effect by four edges, so an off-by-one in the synchroniser or commit timing is visible in the per-cycle comparison against the queue-based model. With the 4-bit nibble default, every select code and the 12-bit word can be set to distinct hand-chosen patterns. That way a crossed nibble lane or a wrong bus half shows up in the code value.

// File: rtl/nib_dac_pkg.sv
package nib_dac_pkg;

  // Holding-register select; bit 1 / bit 0 of the select port.
  typedef enum logic [1:0] {
    SEL_LO_MID = 2'b00,
    SEL_MID    = 2'b01,
    SEL_LO     = 2'b10,
    SEL_HI     = 2'b11
  } nib_sel_e;

  // Control pins, all active low, kept together through the synchroniser.
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
    logic clr_n;
  } nib_ctl_t;

  localparam int CTL_W = $bits(nib_ctl_t);

endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {DEPTH{RST_VAL}};
    else     chain <= {chain[DEPTH-2:0], d};
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/nib_input_bank.sv
module nib_input_bank
  import nib_dac_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_act,
  input  nib_sel_e           sel,
  input  logic [2*NIB_W-1:0] bus,
  output logic [3*NIB_W-1:0] word
);
  localparam int BUS_W = 2 * NIB_W;

  logic             act_q;
  logic [BUS_W-1:0] cap_bus;
  nib_sel_e         cap_sel;
  logic [NIB_W-1:0] lo_q, mid_q, hi_q;
  logic             commit;

  assign commit = act_q && !wr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      cap_bus <= '0;
      cap_sel <= SEL_LO_MID;
      lo_q    <= '0;
      mid_q   <= '0;
      hi_q    <= '0;
    end else begin
      act_q <= wr_act;
      if (wr_act) begin
        cap_bus <= bus;
        cap_sel <= sel;
      end
      if (commit) begin
        unique case (cap_sel)
          SEL_LO_MID: begin
            lo_q  <= cap_bus[NIB_W-1:0];
            mid_q <= cap_bus[BUS_W-1:NIB_W];
          end
          SEL_LO:  lo_q  <= cap_bus[NIB_W-1:0];
          SEL_MID: mid_q <= cap_bus[BUS_W-1:NIB_W];
          SEL_HI:  hi_q  <= cap_bus[NIB_W-1:0];
        endcase
      end
    end
  end

  assign word = {hi_q, mid_q, lo_q};

  // R6
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(act_q && !wr_act) |=> $stable(word));

  // R5
  hi_only_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !wr_act && cap_sel == SEL_HI) |=> $stable(word[BUS_W-1:0]));

  // R2
  lo_mid_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !wr_act && cap_sel == SEL_LO_MID) |=> $stable(word[3*NIB_W-1:BUS_W]));
endmodule

// File: rtl/nib_dac_latch.sv
module nib_dac_latch #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_s_n,
  input  logic              ld_s_n,
  input  logic [CODE_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output logic              is_zero
);
  logic [CODE_W-1:0] code_q, code_nxt;
  logic              zero_q;

  always_comb begin
    if (!clr_s_n)     code_nxt = '0;
    else if (!ld_s_n) code_nxt = word;
    else              code_nxt = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      zero_q <= 1'b1;
    end else begin
      code_q <= code_nxt;
      zero_q <= (code_nxt == '0);
    end
  end

  assign code    = code_q;
  assign is_zero = zero_q;

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_s_n |=> code == '0);

  // R8
  load_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_s_n && !ld_s_n) |=> code == $past(word));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    is_zero == (code == '0));
endmodule

// File: rtl/nib_dac_if.sv
module nib_dac_if
  import nib_dac_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               ld_n,
  input  logic               clr_n,
  input  logic [1:0]         sel,
  input  logic [2*NIB_W-1:0] data,
  output logic [3*NIB_W-1:0] dac_code,
  output logic               dac_zero
);
  localparam int CODE_W = 3 * NIB_W;

  nib_ctl_t          ctl_raw, ctl_s;
  logic [CODE_W-1:0] word;
  logic              wr_act;

  assign ctl_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n, clr_n: clr_n};

  nib_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({CTL_W{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  assign wr_act = !ctl_s.cs_n && !ctl_s.wr_n;

  nib_input_bank #(.NIB_W(NIB_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_act (wr_act),
    .sel    (nib_sel_e'(sel)),
    .bus    (data),
    .word   (word)
  );

  nib_dac_latch #(.CODE_W(CODE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .clr_s_n (ctl_s.clr_n),
    .ld_s_n  (ctl_s.ld_n),
    .word    (word),
    .code    (dac_code),
    .is_zero (dac_zero)
  );

  // R7
  code_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_s.ld_n && ctl_s.clr_n) |=> $stable(dac_code));
endmodule

// File: tb/nib_dac_if_test.sv
`timescale 1ns/1ps
module nib_dac_if_test;
  localparam int NW = 4;
  localparam int S  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [2*NW-1:0] data = '0;
  logic [3*NW-1:0] dac_code;
  logic dac_zero;

  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  nib_dac_if #(.NIB_W(NW), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
    .clr_n(clr_n), .sel(sel), .data(data), .dac_code(dac_code),
    .dac_zero(dac_zero)
  );

  // Behavioural reference: a queue stands in for the synchroniser delay.
  logic [3:0] hq[$];
  int  m_lat = 0, m_dac = 0, m_cbus = 0, m_csel = 0;
  bit  m_prev = 0, m_zero = 1;

  always @(posedge clk) begin
    logic [3:0] s;
    bit act;
    int old_lat;
    if (rst) begin
      hq.delete();
      for (int i = 0; i < S; i++) hq.push_back(4'hF);
      m_lat = 0; m_dac = 0; m_zero = 1; m_prev = 0; m_cbus = 0; m_csel = 0;
    end else begin
      s = hq.pop_front();
      hq.push_back({cs_n, wr_n, ld_n, clr_n});
      act = !s[3] && !s[2];
      old_lat = m_lat;
      if (m_prev && !act) begin
        case (m_csel)
          0: m_lat = (m_lat & 'hF00) | (m_cbus & 'hFF);
          2: m_lat = (m_lat & 'hFF0) | (m_cbus & 'h0F);
          1: m_lat = (m_lat & 'hF0F) | (m_cbus & 'hF0);
          default: m_lat = (m_lat & 'h0FF) | ((m_cbus & 'h0F) << 8);
        endcase
      end
      if (!s[0]) m_dac = 0;
      else if (!s[1]) m_dac = old_lat;
      m_zero = (m_dac == 0);
      if (act) begin m_cbus = int'(data); m_csel = int'(sel); end
      m_prev = act;
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      checks++;
      if (int'(dac_code) != m_dac || dac_zero != m_zero) begin
        errors++;
        $display("FAIL %s model: code=%03h zero=%0b expected code=%03h zero=%0b",
                 cur_req, dac_code, dac_zero, m_dac, m_zero);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic c, input logic w, input logic [1:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    sel = a; data = d;
    cs_n = c; wr_n = w;
    idle(2);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(S + 4);
  endtask

  task automatic pulse_load();
    @(negedge clk); ld_n = 1'b0;
    idle(2); ld_n = 1'b1;
    idle(S + 3);
  endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    run = 1;
    idle(1);
    // R1 reset state
    cur_req = "R1";
    chk("R1 code", int'(dac_code), 0);
    chk("R1 zero", int'(dac_zero), 1);
    pulse_load();
    chk("R1 load after reset", int'(dac_code), 0);

    // R2 8-bit transfer, R7 double buffering
    cur_req = "R2";
    bus_cycle(1'b0, 1'b0, 2'b00, 8'hA5);
    chk("R7 no update before load", int'(dac_code), 0);
    pulse_load();
    chk("R2 lo+mid", int'(dac_code), 'h0A5);

    // R5 high nibble from data[3:0]
    cur_req = "R5";
    bus_cycle(1'b0, 1'b0, 2'b11, 8'hF3);
    pulse_load();
    chk("R5 hi", int'(dac_code), 'h3A5);

    // R3 low nibble only
    cur_req = "R3";
    bus_cycle(1'b0, 1'b0, 2'b10, 8'hEC);
    pulse_load();
    chk("R3 lo", int'(dac_code), 'h3AC);

    // R4 middle nibble from data[7:4]
    cur_req = "R4";
    bus_cycle(1'b0, 1'b0, 2'b01, 8'h7E);
    pulse_load();
    chk("R4 mid", int'(dac_code), 'h37C);

    // R6 single strobe ignored
    cur_req = "R6";
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    bus_cycle(1'b0, 1'b1, 2'b11, 8'h00);
    pulse_load();
    chk("R6 half strobe ignored", int'(dac_code), 'h37C);

    // R9 clear, R11 flag, R10 holding registers kept
    cur_req = "R9";
    @(negedge clk); clr_n = 1'b0;
    idle(2); clr_n = 1'b1;
    idle(S + 3);
    chk("R9 cleared", int'(dac_code), 0);
    chk("R11 zero flag set", int'(dac_zero), 1);
    cur_req = "R10";
    pulse_load();
    chk("R10 restored", int'(dac_code), 'h37C);
    chk("R11 zero flag clear", int'(dac_zero), 0);

    // R9 priority over load, then R8 transparency
    cur_req = "R9";
    @(negedge clk); clr_n = 1'b0; ld_n = 1'b0;
    idle(S + 4);
    chk("R9 clear beats load", int'(dac_code), 0);
    cur_req = "R8";
    clr_n = 1'b1;
    idle(S + 3);
    chk("R8 follows word", int'(dac_code), 'h37C);
    bus_cycle(1'b0, 1'b0, 2'b10, 8'h01);
    chk("R8 transparent update", int'(dac_code), 'h371);
    ld_n = 1'b1;
    idle(S + 3);

    // R12 synchroniser latency on load
    cur_req = "R12";
    bus_cycle(1'b0, 1'b0, 2'b11, 8'h09);
    @(negedge clk); ld_n = 1'b0;
    for (int i = 0; i < S; i++) begin
      @(negedge clk);
      chk("R12 before latency", int'(dac_code), 'h371);
    end
    @(negedge clk);
    chk("R12 at latency", int'(dac_code), 'h971);
    ld_n = 1'b1;
    idle(S + 3);

    finish_up();
  end
endmodule